// File: doc/BRIEF.md
# GPIO Bank with Edge and Level Interrupts

This block is a bank of general-purpose pins managed through a small word-addressed register port. Each pin owns one bit in every register. A pin can drive a stored output value when its output-enable bit is set. Software changes output values in three ways: by writing the whole output word, or by writing a mask to a set strobe or a clear strobe. The strobes change only the bits written as one, so no read-modify-write is needed.

Incoming pin levels pass through a two-stage synchronizer. The synchronized levels are readable, and they feed a per-pin interrupt detector. Each pin has two independent mode bits. One picks edge or level triggering. The other picks rising/high or falling/low sense. Detected events latch into a status word that software acknowledges by writing ones. Status bits that are enabled are ORed into one registered interrupt line.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads 0, and `pin_out`, `pin_oe` and `irq` are 0.
- R2: A write to offset 0x04 replaces the output word. The new value appears on `pin_out` and reads back at 0x04 after one clock edge.
- R3: A write to offset 0x1C sets every output bit whose write-data bit is 1 and leaves the other output bits unchanged.
- R4: A write to offset 0x20 clears every output bit whose write-data bit is 1 and leaves the other output bits unchanged.
- R5: The output-enable word at offset 0x08 appears on `pin_oe` and changes only when that offset is written.
- R6: Offset 0x00 returns the pin levels as seen after two clock edges of synchronization. Writes to 0x00 have no effect.
- R7: With edge mode (mode-A bit at 0x14 = 1) and rising sense (mode-B bit at 0x18 = 0), a low-to-high pin transition sets the status bit at 0x0C. A high-to-low transition does not. The bit stays set after the pin returns low.
- R8: With edge mode and falling sense (mode-B bit = 1), only a high-to-low transition sets the status bit.
- R9: With level mode (mode-A bit = 0), the status bit sets while the pin is at its active level: high for mode-B = 0, low for mode-B = 1. If it is acknowledged while the pin is still active, it reads 0 for one cycle and then sets again. If it is acknowledged after the pin goes inactive, it stays clear.
- R10: Writing to 0x0C clears each status bit written as 1 and keeps each bit written as 0. Writing all ones clears every bit.
- R11: `irq` is a registered OR of status ANDed with the enable word at 0x10. It follows a change of enable or status by one clock cycle. A pin whose enable bit is 0 cannot raise `irq`.
- R12: If an edge event and an acknowledge reach the same status bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output values to the pads |
| pin_oe | output | 32 | Per-pin drive enable |
| irq | output | 1 | Combined interrupt request |

## Verification
Two functions can hit the same status bit in the same cycle: event detection and the write-one acknowledge. The bench first latches a rising-edge bit. It then raises the pin again and times the acknowledge write so that it lands on the exact clock edge where the new edge is detected, two edges after the pin change. The bit must then still read 1. For level mode, the bench acknowledges while the pin is held active and checks cycle by cycle that the bit reads 0 once and is set again on the next cycle. A plain acknowledge with no competing event serves as the control case.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFF_IN    = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_OUT   = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_OE    = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_EN    = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_TRIG  = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_SENSE = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_SET   = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 6'h20;

  // A transition into the active sense: current active, previous not.
  function automatic logic [DATA_W-1:0] edge_hits(
      input logic [DATA_W-1:0] cur,
      input logic [DATA_W-1:0] prev,
      input logic [DATA_W-1:0] sense);
    return (cur ^ sense) & ~(prev ^ sense);
  endfunction

  // Level currently at its active value.
  function automatic logic [DATA_W-1:0] level_hits(
      input logic [DATA_W-1:0] cur,
      input logic [DATA_W-1:0] sense);
    return cur ^ sense;
  endfunction

  // New status bit: a hit wins over an acknowledge.
  function automatic logic status_next(input logic cur, input logic hit,
                                       input logic ack);
    return hit | (cur & ~ack);
  endfunction

  // Output word update for the three write paths.
  function automatic logic [DATA_W-1:0] out_next(
      input logic [DATA_W-1:0] cur,
      input logic [DATA_W-1:0] wdata,
      input logic              do_load,
      input logic              do_set,
      input logic              do_clr);
    if (do_load)     return wdata;
    else if (do_set) return cur | wdata;
    else if (do_clr) return cur & ~wdata;
    else             return cur;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_sync,
  input  logic [NPINS-1:0] trig_edge,
  input  logic [NPINS-1:0] sense_inv,
  input  logic [NPINS-1:0] ack,
  output logic [NPINS-1:0] status,
  output logic [NPINS-1:0] edge_evt,
  output logic [NPINS-1:0] level_evt
);
  logic [NPINS-1:0]  prev_q;
  logic [DATA_W-1:0] edge_full;
  logic [DATA_W-1:0] lvl_full;
  logic [NPINS-1:0]  hit;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_sync;
  end

  assign edge_full = edge_hits(DATA_W'(pin_sync), DATA_W'(prev_q), DATA_W'(sense_inv));
  assign lvl_full  = level_hits(DATA_W'(pin_sync), DATA_W'(sense_inv));

  // Edges beat an acknowledge; a level yields to it for one cycle.
  assign edge_evt  = edge_full[NPINS-1:0] & trig_edge;
  assign level_evt = lvl_full[NPINS-1:0] & ~trig_edge & ~ack;
  assign hit       = edge_evt | level_evt;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic st_q;
    always_ff @(posedge clk) begin
      if (!rst_n) st_q <= 1'b0;
      else        st_q <= status_next(st_q, hit[i], ack[i]);
    end
    assign status[i] = st_q;
  end

  // R12
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt & ack) != '0 |=> (status & $past(edge_evt & ack)) == $past(edge_evt & ack));

  // R10
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack & ~hit) != '0 |=> (status & $past(ack & ~hit)) == '0);

  // R9
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~$past(status) & ~$past(hit)) == '0);

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic [NPINS-1:0] wdata_n;
  logic [NPINS-1:0] out_q, oe_q, en_q, trig_q, sense_q;
  logic [NPINS-1:0] pin_sync, status, ack, edge_evt, level_evt;
  logic [DATA_W-1:0] out_upd;
  logic wr_out, wr_oe, wr_stat, wr_en, wr_trig, wr_sense, wr_set, wr_clr;
  logic irq_q;

  assign wdata_n  = bus_wdata[NPINS-1:0];
  assign wr_out   = bus_wr && (bus_addr == OFF_OUT);
  assign wr_oe    = bus_wr && (bus_addr == OFF_OE);
  assign wr_stat  = bus_wr && (bus_addr == OFF_STAT);
  assign wr_en    = bus_wr && (bus_addr == OFF_EN);
  assign wr_trig  = bus_wr && (bus_addr == OFF_TRIG);
  assign wr_sense = bus_wr && (bus_addr == OFF_SENSE);
  assign wr_set   = bus_wr && (bus_addr == OFF_SET);
  assign wr_clr   = bus_wr && (bus_addr == OFF_CLR);

  assign ack     = wr_stat ? wdata_n : '0;
  assign out_upd = out_next(DATA_W'(out_q), DATA_W'(wdata_n), wr_out, wr_set, wr_clr);

  gpio_sync #(.WIDTH(NPINS), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  gpio_irq_detect #(.NPINS(NPINS)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_sync  (pin_sync),
    .trig_edge (trig_q),
    .sense_inv (sense_q),
    .ack       (ack),
    .status    (status),
    .edge_evt  (edge_evt),
    .level_evt (level_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q   <= '0;
      oe_q    <= '0;
      en_q    <= '0;
      trig_q  <= '0;
      sense_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      out_q <= out_upd[NPINS-1:0];
      if (wr_oe)    oe_q    <= wdata_n;
      if (wr_en)    en_q    <= wdata_n;
      if (wr_trig)  trig_q  <= wdata_n;
      if (wr_sense) sense_q <= wdata_n;
      irq_q <= |(status & en_q);
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFF_IN:    bus_rdata = DATA_W'(pin_sync);
      OFF_OUT:   bus_rdata = DATA_W'(out_q);
      OFF_OE:    bus_rdata = DATA_W'(oe_q);
      OFF_STAT:  bus_rdata = DATA_W'(status);
      OFF_EN:    bus_rdata = DATA_W'(en_q);
      OFF_TRIG:  bus_rdata = DATA_W'(trig_q);
      OFF_SENSE: bus_rdata = DATA_W'(sense_q);
      default:   bus_rdata = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = oe_q;
  assign irq     = irq_q;

  // R3
  set_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> (pin_out & $past(wdata_n)) == $past(wdata_n));

  // R4
  clr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (pin_out & $past(wdata_n)) == '0);

  // R5
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_oe |=> $stable(pin_oe));

  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((status & en_q) != '0));

endmodule

// File: tb/gpio_bank_test.sv
`timescale 1ns/100ps
module gpio_bank_test;
  localparam logic [5:0] A_IN = 6'h00, A_OUT = 6'h04, A_OE = 6'h08, A_STAT = 6'h0C,
                         A_EN = 6'h10, A_TRIG = 6'h14, A_SENSE = 6'h18,
                         A_SET = 6'h1C, A_CLR = 6'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pins = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] obs;
  event        mon_ev;

  always #2.5 clk = ~clk;

  gpio_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pins),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // Monitor: pops the expected item and compares it with the observation.
  always @(mon_ev) begin
    logic [31:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    checks++;
    if (obs !== e) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, obs, e);
    end
  end

  task automatic chk(input logic [31:0] got, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    obs = got;
    -> mon_ev;
    wait (exp_q.size() == 0);
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] e, input string t);
    bus_addr = a;
    #0.2;
    chk(bus_rdata, e, t);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    rd_chk(A_OUT, 0, "R1 out");      cyc(1);
    rd_chk(A_OE, 0, "R1 oe");        cyc(1);
    rd_chk(A_STAT, 0, "R1 stat");    cyc(1);
    rd_chk(A_EN, 0, "R1 en");        cyc(1);
    rd_chk(A_TRIG, 0, "R1 trig");    cyc(1);
    rd_chk(A_SENSE, 0, "R1 sense");  cyc(1);
    chk(pin_out, 0, "R1 pin_out");
    chk(pin_oe, 0, "R1 pin_oe");
    chk({31'b0, irq}, 0, "R1 irq");

    // R2 whole-word load
    wr(A_OUT, 32'hA5A5_0F0F);
    chk(pin_out, 32'hA5A5_0F0F, "R2 pin_out");
    rd_chk(A_OUT, 32'hA5A5_0F0F, "R2 readback"); cyc(1);
    // R3 set strobe
    wr(A_SET, 32'h0000_F0F0);
    chk(pin_out, 32'hA5A5_FFFF, "R3 set");
    // R4 clear strobe
    wr(A_CLR, 32'hA5A5_0000);
    chk(pin_out, 32'h0000_FFFF, "R4 clear");
    rd_chk(A_OUT, 32'h0000_FFFF, "R4 readback"); cyc(1);
    // R5 output enable
    wr(A_OE, 32'h1234_5678);
    chk(pin_oe, 32'h1234_5678, "R5 pin_oe");
    wr(A_OUT, 32'h0);
    chk(pin_oe, 32'h1234_5678, "R5 oe unchanged by other write");

    // R6 synchronized input, two edges of latency, write ignored
    pins = 32'h8000_0001;
    cyc(1);
    rd_chk(A_IN, 32'h0, "R6 one edge");
    cyc(1);
    rd_chk(A_IN, 32'h8000_0001, "R6 two edges");
    cyc(1);
    wr(A_IN, 32'hFFFF_FFFF);
    rd_chk(A_IN, 32'h8000_0001, "R6 write ignored"); cyc(1);
    pins = 32'h0;
    cyc(4);
    // R10 all-ones acknowledge (level-high bits latched above)
    wr(A_STAT, 32'hFFFF_FFFF);
    rd_chk(A_STAT, 32'h0, "R10 ack all"); cyc(1);

    // Pins 0..7 edge; 4..7 falling; others level-high
    wr(A_TRIG, 32'h0000_00FF);
    wr(A_SENSE, 32'h0000_00F0);
    cyc(2);
    rd_chk(A_STAT, 32'h0, "R9 no level hit while low"); cyc(1);

    // R7 rising edge
    pins[0] = 1'b1; cyc(4);
    rd_chk(A_STAT, 32'h1, "R7 rise sets"); cyc(1);
    pins[0] = 1'b0; cyc(4);
    rd_chk(A_STAT, 32'h1, "R7 stays after fall"); cyc(1);
    wr(A_STAT, 32'h1);
    rd_chk(A_STAT, 32'h0, "R7 acked"); cyc(1);
    pins[0] = 1'b0; cyc(1);

    // R8 falling edge
    pins[4] = 1'b1; cyc(4);
    rd_chk(A_STAT, 32'h0, "R8 rise ignored"); cyc(1);
    pins[4] = 1'b0; cyc(4);
    rd_chk(A_STAT, 32'h10, "R8 fall sets"); cyc(1);
    wr(A_STAT, 32'h10);

    // R10 partial acknowledge
    pins[2:1] = 2'b11; cyc(4);
    rd_chk(A_STAT, 32'h6, "R10 two set"); cyc(1);
    wr(A_STAT, 32'h2);
    rd_chk(A_STAT, 32'h4, "R10 zero bit kept"); cyc(1);
    wr(A_STAT, 32'h4);
    rd_chk(A_STAT, 32'h0, "R10 cleared"); cyc(1);
    pins[2:1] = 2'b00; cyc(4);

    // R9 level-high: ack while active re-sets next cycle
    pins[9] = 1'b1; cyc(4);
    rd_chk(A_STAT, 32'h200, "R9 level sets"); cyc(1);
    wr(A_STAT, 32'h200);
    rd_chk(A_STAT, 32'h0, "R9 ack cycle"); cyc(1);
    rd_chk(A_STAT, 32'h200, "R9 re-set next cycle"); cyc(1);
    pins[9] = 1'b0; cyc(4);
    wr(A_STAT, 32'h200);
    cyc(3);
    rd_chk(A_STAT, 32'h0, "R9 stays clear when inactive"); cyc(1);
    // R9 level-low on pin 10 (pin held low)
    wr(A_SENSE, 32'h0000_04F0);
    cyc(2);
    rd_chk(A_STAT, 32'h400, "R9 level-low sets"); cyc(1);
    pins[10] = 1'b1; cyc(4);
    wr(A_STAT, 32'h400);
    cyc(3);
    rd_chk(A_STAT, 32'h0, "R9 level-low inactive stays clear"); cyc(1);

    // R11 enable masking and one-cycle lag
    pins[11] = 1'b1; cyc(4);
    rd_chk(A_STAT, 32'h800, "R11 status set"); cyc(1);
    chk({31'b0, irq}, 0, "R11 masked");
    wr(A_EN, 32'h800);
    chk({31'b0, irq}, 0, "R11 lag");
    cyc(1);
    chk({31'b0, irq}, 1, "R11 asserted");
    wr(A_EN, 32'h0);
    cyc(1);
    chk({31'b0, irq}, 0, "R11 masked again");
    pins[11] = 1'b0; cyc(4);
    wr(A_STAT, 32'h800);
    rd_chk(A_STAT, 32'h0, "R11 cleanup"); cyc(1);

    // R12 edge and acknowledge on the same edge
    pins[0] = 1'b1; cyc(4);
    pins[0] = 1'b0; cyc(4);
    rd_chk(A_STAT, 32'h1, "R12 pre-set"); cyc(1);
    pins[0] = 1'b1;
    cyc(2);
    wr(A_STAT, 32'h1);
    rd_chk(A_STAT, 32'h1, "R12 event wins"); cyc(1);
    wr(A_STAT, 32'h1);
    rd_chk(A_STAT, 32'h0, "R12 control ack"); cyc(1);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule